// File: doc/BRIEF.md
# Microcoded Sequencer for a Multicycle Datapath

This block is the control unit of a multicycle processor datapath. It runs a small microprogram held in a read-only store. Each step of the microprogram is a narrow word made of encoded fields: ALU operation, first operand source, second operand source, register write-back destination, memory action, program-counter write mode and sequencing mode. A decoder expands these fields into the wide set of strobes and multiplexer selects that drive the datapath.

A micro-program counter (micro-PC) picks the next step. Its 2-bit sequencing field chooses one of four sources. It can return to the first step (fetch), index one of two opcode-driven dispatch tables, or advance by one. The first dispatch table serves the decode step. The second serves the address step shared by loads and stores. The supported instructions are register-register ALU, load word, store word, branch-on-equal, jump and OR-immediate.

The block has no state other than the micro-PC. Its inputs are the opcode, the clock and a synchronous reset. The datapath is not part of this block.

Top module: `ucode_ctrl`

## Requirements
- R1: A synchronous reset forces the micro-PC to address 0. In the cycle after reset is released, the outputs show the fetch step.
- R2: The fetch step (address 0) asserts memRead, irWrite and pcWrite, with iorD=0, pcSource=00, aluOp=00 (add), aluSelA=0 (PC) and aluSelB=00 (constant 4).
- R3: In the decode step (address 1), the next address comes from table 1. Opcode 000000 goes to 6, 000010 to 9, 000100 to 8, 100011 and 101011 to 2, and 001101 to 10.
- R4: An opcode that is not listed in a dispatch table sends the micro-PC to address 0.
- R5: In the address step (address 2), table 2 sends opcode 100011 to address 3 and opcode 101011 to address 5.
- R6: The sequencing code 3 advances the micro-PC by one. This applies at addresses 0, 3, 6 and 10.
- R7: The sequencing code 0 returns to fetch. This applies at addresses 4, 5, 7, 8, 9 and 11.
- R8: aluOp carries the ALU field: add=00, subtract=01, function code=10, OR=11. The branch step (address 8) subtracts.
- R9: aluSelA=1 selects Reg[rs]. aluSelB selects the second operand: 00 for 4, 01 for Reg[rt], 10 for the shifted extended immediate, 11 for the extended immediate. extOp=1 means sign extension and extOp=0 means zero extension (used by OR-immediate).
- R10: Write-back decodes to regWrite, regDst and memToReg. Reg[rt]<=memory is 1,0,1. Reg[rd]<=ALUOut is 1,1,0. Reg[rt]<=ALUOut is 1,0,0.
- R11: The memory field decodes to memRead, memWrite, iorD and irWrite. A read at PC is 1,0,0,1. A read at ALUOut is 1,0,1,0. A write at ALUOut is 0,1,1,0.
- R12: The PC write field has three modes. An unconditional write of the ALU result gives pcWrite with pcSource=00. A conditional write of ALUOut gives pcWriteCond with pcSource=01. A jump gives pcWrite with pcSource=10. Fields left unused decode to 0.
- R13: The opcode is ignored at every address except 1 and 2.
- R14: A reset that coincides with a dispatch step overrides it, and the micro-PC goes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the instruction register |
| aluOp | output | 2 | ALU operation code |
| aluSelA | output | 1 | First ALU operand select |
| aluSelB | output | 2 | Second ALU operand select |
| extOp | output | 1 | 1 = sign extend, 0 = zero extend |
| regWrite | output | 1 | Register file write enable |
| regDst | output | 1 | 1 = rd destination, 0 = rt |
| memToReg | output | 1 | 1 = write-back from memory data |
| memRead | output | 1 | Memory read strobe |
| memWrite | output | 1 | Memory write strobe |
| iorD | output | 1 | 1 = memory address from ALUOut |
| irWrite | output | 1 | Instruction register load |
| pcWrite | output | 1 | Unconditional PC write |
| pcWriteCond | output | 1 | PC write when ALU zero |
| pcSource | output | 2 | PC source: 0 ALU, 1 ALUOut, 2 jump target |

## Verification
Two functions can fall in the same cycle: reset and an opcode dispatch. The bench raises reset for one cycle exactly while the micro-PC sits at the decode step, with a listed opcode on the input. It judges the result by requiring the fetch strobes in the next cycle. The opcode also changes on every cycle, so each sequential or return step is checked against a behavioural model. This shows that an opcode present outside a dispatch step changes nothing.

// File: rtl/ucode_ctrl_pkg.sv
package ucode_ctrl_pkg;

  typedef enum logic [1:0] {ALU_ADD = 2'd0, ALU_SUB = 2'd1, ALU_FUNC = 2'd2, ALU_OR = 2'd3} aluFld_e;
  typedef enum logic {SRC1_PC = 1'b0, SRC1_RS = 1'b1} src1Fld_e;
  typedef enum logic [2:0] {
    SRC2_NONE = 3'd0, SRC2_FOUR = 3'd1, SRC2_RT = 3'd2,
    SRC2_EXTSHFT = 3'd3, SRC2_EXT = 3'd4, SRC2_EXT0 = 3'd5
  } src2Fld_e;
  typedef enum logic [1:0] {DST_NONE = 2'd0, DST_RD_ALU = 2'd1, DST_RT_ALU = 2'd2, DST_RT_MEM = 2'd3} destFld_e;
  typedef enum logic [1:0] {MEM_NONE = 2'd0, MEM_READ_PC = 2'd1, MEM_READ_ALU = 2'd2, MEM_WRITE_ALU = 2'd3} memFld_e;
  typedef enum logic [1:0] {PCW_NONE = 2'd0, PCW_ALU = 2'd1, PCW_COND = 2'd2, PCW_JUMP = 2'd3} pcwFld_e;
  // sequencing codes: the values themselves are the select encoding
  typedef enum logic [1:0] {SEQ_FETCH = 2'd0, SEQ_DISP1 = 2'd1, SEQ_DISP2 = 2'd2, SEQ_NEXT = 2'd3} seqFld_e;

  typedef struct packed {
    aluFld_e  alu;
    src1Fld_e src1;
    src2Fld_e src2;
    destFld_e dest;
    memFld_e  mem;
    pcwFld_e  pcw;
    seqFld_e  seq;
  } uinstr_t;

  typedef struct packed {
    logic [1:0] aluOp;
    logic       aluSelA;
    logic [1:0] aluSelB;
    logic       extOp;
    logic       regWrite;
    logic       regDst;
    logic       memToReg;
    logic       memRead;
    logic       memWrite;
    logic       iorD;
    logic       irWrite;
    logic       pcWrite;
    logic       pcWriteCond;
    logic [1:0] pcSource;
  } ctrlStrobes_t;

  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_JMP   = 6'b000010;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_ORI   = 6'b001101;
  localparam logic [5:0] OP_LW    = 6'b100011;
  localparam logic [5:0] OP_SW    = 6'b101011;

  localparam int UA_FETCH  = 0;
  localparam int UA_DECODE = 1;
  localparam int UA_MEMADR = 2;
  localparam int UA_LDRD   = 3;
  localparam int UA_LDWB   = 4;
  localparam int UA_STWR   = 5;
  localparam int UA_REXE   = 6;
  localparam int UA_RWB    = 7;
  localparam int UA_BRCH   = 8;
  localparam int UA_JUMP   = 9;
  localparam int UA_OREXE  = 10;
  localparam int UA_ORWB   = 11;

endpackage

// File: rtl/ucode_dispatch.sv
module ucode_dispatch
  import ucode_ctrl_pkg::*;
#(
  parameter int OP_W  = 6,
  parameter int UPC_W = 4,
  parameter int TABLE = 1
) (
  input  logic [OP_W-1:0]  opcode,
  output logic [UPC_W-1:0] target
);

  localparam logic [UPC_W-1:0] MISS = '0;

  generate
    if (TABLE == 1) begin : g_tbl1
      always_comb begin
        case (opcode)
          OP_RTYPE: target = UPC_W'(UA_REXE);
          OP_JMP:   target = UPC_W'(UA_JUMP);
          OP_BEQ:   target = UPC_W'(UA_BRCH);
          OP_ORI:   target = UPC_W'(UA_OREXE);
          OP_LW,
          OP_SW:    target = UPC_W'(UA_MEMADR);
          default:  target = MISS;
        endcase
      end
    end else begin : g_tbl2
      always_comb begin
        case (opcode)
          OP_LW:   target = UPC_W'(UA_LDRD);
          OP_SW:   target = UPC_W'(UA_STWR);
          default: target = MISS;
        endcase
      end
    end
  endgenerate

endmodule

// File: rtl/ucode_store.sv
module ucode_store
  import ucode_ctrl_pkg::*;
#(
  parameter int UPC_W = 4
) (
  input  logic [UPC_W-1:0] addr,
  output uinstr_t          word
);

  always_comb begin
    word = '0;
    case (int'(addr))
      UA_FETCH: begin
        word.alu = ALU_ADD;  word.src1 = SRC1_PC; word.src2 = SRC2_FOUR;
        word.mem = MEM_READ_PC; word.pcw = PCW_ALU; word.seq = SEQ_NEXT;
      end
      UA_DECODE: begin
        word.alu = ALU_ADD;  word.src1 = SRC1_PC; word.src2 = SRC2_EXTSHFT;
        word.seq = SEQ_DISP1;
      end
      UA_MEMADR: begin
        word.alu = ALU_ADD;  word.src1 = SRC1_RS; word.src2 = SRC2_EXT;
        word.seq = SEQ_DISP2;
      end
      UA_LDRD: begin
        word.mem = MEM_READ_ALU; word.seq = SEQ_NEXT;
      end
      UA_LDWB: begin
        word.dest = DST_RT_MEM; word.seq = SEQ_FETCH;
      end
      UA_STWR: begin
        word.mem = MEM_WRITE_ALU; word.seq = SEQ_FETCH;
      end
      UA_REXE: begin
        word.alu = ALU_FUNC; word.src1 = SRC1_RS; word.src2 = SRC2_RT;
        word.seq = SEQ_NEXT;
      end
      UA_RWB: begin
        word.dest = DST_RD_ALU; word.seq = SEQ_FETCH;
      end
      UA_BRCH: begin
        word.alu = ALU_SUB;  word.src1 = SRC1_RS; word.src2 = SRC2_RT;
        word.pcw = PCW_COND; word.seq = SEQ_FETCH;
      end
      UA_JUMP: begin
        word.pcw = PCW_JUMP; word.seq = SEQ_FETCH;
      end
      UA_OREXE: begin
        word.alu = ALU_OR;   word.src1 = SRC1_RS; word.src2 = SRC2_EXT0;
        word.seq = SEQ_NEXT;
      end
      UA_ORWB: begin
        word.dest = DST_RT_ALU; word.seq = SEQ_FETCH;
      end
      default: word = '0;
    endcase
  end

endmodule

// File: rtl/ucode_seq.sv
module ucode_seq
  import ucode_ctrl_pkg::*;
#(
  parameter int OP_W  = 6,
  parameter int UPC_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OP_W-1:0]  opcode,
  input  seqFld_e          addrCtl,
  output logic [UPC_W-1:0] upc
);

  logic [UPC_W-1:0] disp1Tgt;
  logic [UPC_W-1:0] disp2Tgt;
  logic [UPC_W-1:0] upcNext;

  ucode_dispatch #(.OP_W(OP_W), .UPC_W(UPC_W), .TABLE(1)) u_disp1 (
    .opcode (opcode),
    .target (disp1Tgt)
  );

  ucode_dispatch #(.OP_W(OP_W), .UPC_W(UPC_W), .TABLE(2)) u_disp2 (
    .opcode (opcode),
    .target (disp2Tgt)
  );

  always_comb begin
    case (addrCtl)
      SEQ_FETCH: upcNext = '0;
      SEQ_DISP1: upcNext = disp1Tgt;
      SEQ_DISP2: upcNext = disp2Tgt;
      default:   upcNext = upc + UPC_W'(1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) upc <= '0;
    else     upc <= upcNext;
  end

  // R5
  disp2_land_chk: assert property (@(posedge clk) disable iff (rst)
    (addrCtl == SEQ_DISP2 && opcode == OP_LW) |=> (upc == UPC_W'(UA_LDRD)));

  // R4
  disp1_miss_chk: assert property (@(posedge clk) disable iff (rst)
    (addrCtl == SEQ_DISP1 && opcode == 6'b111111) |=> (upc == '0));

endmodule

// File: rtl/ucode_decode.sv
module ucode_decode
  import ucode_ctrl_pkg::*;
(
  input  uinstr_t      word,
  output ctrlStrobes_t strobes
);

  always_comb begin
    strobes = '0;
    strobes.aluOp   = word.alu;
    strobes.aluSelA = (word.src1 == SRC1_RS);

    case (word.src2)
      SRC2_FOUR:    begin strobes.aluSelB = 2'b00; strobes.extOp = 1'b0; end
      SRC2_RT:      begin strobes.aluSelB = 2'b01; strobes.extOp = 1'b0; end
      SRC2_EXTSHFT: begin strobes.aluSelB = 2'b10; strobes.extOp = 1'b1; end
      SRC2_EXT:     begin strobes.aluSelB = 2'b11; strobes.extOp = 1'b1; end
      SRC2_EXT0:    begin strobes.aluSelB = 2'b11; strobes.extOp = 1'b0; end
      default:      begin strobes.aluSelB = 2'b00; strobes.extOp = 1'b0; end
    endcase

    case (word.dest)
      DST_RD_ALU: begin strobes.regWrite = 1'b1; strobes.regDst = 1'b1; end
      DST_RT_ALU: begin strobes.regWrite = 1'b1; end
      DST_RT_MEM: begin strobes.regWrite = 1'b1; strobes.memToReg = 1'b1; end
      default: ;
    endcase

    case (word.mem)
      MEM_READ_PC:   begin strobes.memRead = 1'b1; strobes.irWrite = 1'b1; end
      MEM_READ_ALU:  begin strobes.memRead = 1'b1; strobes.iorD = 1'b1; end
      MEM_WRITE_ALU: begin strobes.memWrite = 1'b1; strobes.iorD = 1'b1; end
      default: ;
    endcase

    case (word.pcw)
      PCW_ALU:  begin strobes.pcWrite = 1'b1; strobes.pcSource = 2'b00; end
      PCW_COND: begin strobes.pcWriteCond = 1'b1; strobes.pcSource = 2'b01; end
      PCW_JUMP: begin strobes.pcWrite = 1'b1; strobes.pcSource = 2'b10; end
      default: ;
    endcase
  end

endmodule

// File: rtl/ucode_ctrl.sv
module ucode_ctrl
  import ucode_ctrl_pkg::*;
#(
  parameter int OP_W  = 6,
  parameter int UPC_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opcode,
  output logic [1:0]      aluOp,
  output logic            aluSelA,
  output logic [1:0]      aluSelB,
  output logic            extOp,
  output logic            regWrite,
  output logic            regDst,
  output logic            memToReg,
  output logic            memRead,
  output logic            memWrite,
  output logic            iorD,
  output logic            irWrite,
  output logic            pcWrite,
  output logic            pcWriteCond,
  output logic [1:0]      pcSource
);

  logic [UPC_W-1:0] upc;
  uinstr_t          word;
  ctrlStrobes_t     strobes;

  ucode_seq #(.OP_W(OP_W), .UPC_W(UPC_W)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .opcode  (opcode),
    .addrCtl (word.seq),
    .upc     (upc)
  );

  ucode_store #(.UPC_W(UPC_W)) u_store (
    .addr (upc),
    .word (word)
  );

  ucode_decode u_decode (
    .word    (word),
    .strobes (strobes)
  );

  assign aluOp       = strobes.aluOp;
  assign aluSelA     = strobes.aluSelA;
  assign aluSelB     = strobes.aluSelB;
  assign extOp       = strobes.extOp;
  assign regWrite    = strobes.regWrite;
  assign regDst      = strobes.regDst;
  assign memToReg    = strobes.memToReg;
  assign memRead     = strobes.memRead;
  assign memWrite    = strobes.memWrite;
  assign iorD        = strobes.iorD;
  assign irWrite     = strobes.irWrite;
  assign pcWrite     = strobes.pcWrite;
  assign pcWriteCond = strobes.pcWriteCond;
  assign pcSource    = strobes.pcSource;

  // R1
  rst_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (irWrite && pcWrite && memRead));

  // R6
  fetch_then_decode_chk: assert property (@(posedge clk) disable iff (rst)
    irWrite |=> (aluSelB == 2'b10 && extOp && !pcWrite && !irWrite));

  // R7
  wb_returns_chk: assert property (@(posedge clk) disable iff (rst)
    regWrite |=> irWrite);

  // R8
  branch_sub_chk: assert property (@(posedge clk) disable iff (rst)
    pcWriteCond |-> (aluOp == 2'b01 && pcSource == 2'b01 && !pcWrite));

endmodule

// File: tb/ucode_ctrl_bench.sv
module ucode_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst;
  logic [5:0] opcode;
  logic [1:0] aluOp, aluSelB, pcSource;
  logic aluSelA, extOp, regWrite, regDst, memToReg, memRead, memWrite;
  logic iorD, irWrite, pcWrite, pcWriteCond;

  int  errors = 0;
  int  checks = 0;
  bit  done = 1'b0;

  always #5 clk = ~clk;

  ucode_ctrl u_ucode_ctrl (
    .clk(clk), .rst(rst), .opcode(opcode),
    .aluOp(aluOp), .aluSelA(aluSelA), .aluSelB(aluSelB), .extOp(extOp),
    .regWrite(regWrite), .regDst(regDst), .memToReg(memToReg),
    .memRead(memRead), .memWrite(memWrite), .iorD(iorD), .irWrite(irWrite),
    .pcWrite(pcWrite), .pcWriteCond(pcWriteCond), .pcSource(pcSource)
  );

  // expected output vector for a micro-address, straight from the requirements
  function automatic logic [16:0] expVec(input int s);
    logic [1:0] op = 2'b00, sb = 2'b00, ps = 2'b00;
    logic sa = 0, ex = 0, rw = 0, rd = 0, m2r = 0, mr = 0, mw = 0, id = 0, ir = 0, pw = 0, pc = 0;
    case (s)
      0:  begin mr = 1; ir = 1; pw = 1; end                     // R2
      1:  begin sb = 2'b10; ex = 1; end
      2:  begin sa = 1; sb = 2'b11; ex = 1; end
      3:  begin mr = 1; id = 1; end
      4:  begin rw = 1; m2r = 1; end
      5:  begin mw = 1; id = 1; end
      6:  begin op = 2'b10; sa = 1; sb = 2'b01; end
      7:  begin rw = 1; rd = 1; end
      8:  begin op = 2'b01; sa = 1; sb = 2'b01; pc = 1; ps = 2'b01; end
      9:  begin pw = 1; ps = 2'b10; end
      10: begin op = 2'b11; sa = 1; sb = 2'b11; end
      11: begin rw = 1; end
      default: ;
    endcase
    return {op, sa, sb, ex, rw, rd, m2r, mr, mw, id, ir, pw, pc, ps};
  endfunction

  function automatic int disp1(input logic [5:0] o);
    case (o)
      6'b000000: return 6;
      6'b000010: return 9;
      6'b000100: return 8;
      6'b001101: return 10;
      6'b100011, 6'b101011: return 2;
      default: return 0;
    endcase
  endfunction

  function automatic int disp2(input logic [5:0] o);
    if (o == 6'b100011) return 3;
    if (o == 6'b101011) return 5;
    return 0;
  endfunction

  task automatic chk(input string tag, input logic [16:0] act, input logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  initial begin
    int mState = 0;
    string tag = "R1";
    logic [15:0] lfsr = 16'hACE1;
    bit midDone = 0;
    logic [5:0] opList [8];
    opList[0] = 6'b000000; opList[1] = 6'b000010; opList[2] = 6'b000100; opList[3] = 6'b100011;
    opList[4] = 6'b101011; opList[5] = 6'b001101; opList[6] = 6'b111111; opList[7] = 6'b001000;
    rst = 1'b1;
    opcode = 6'b000000;
    for (int cyc = 0; cyc < 600; cyc++) begin
      @(negedge clk);
      if (cyc >= 1) begin
        logic [16:0] act, exp;
        act = {aluOp, aluSelA, aluSelB, extOp, regWrite, regDst, memToReg,
               memRead, memWrite, iorD, irWrite, pcWrite, pcWriteCond, pcSource};
        exp = expVec(mState);
        chk(tag, act, exp);                                       // sequencing tag
        chk("R8 aluOp", {15'd0, act[16:15]}, {15'd0, exp[16:15]});
        chk("R9 operands", {13'd0, act[14:11]}, {13'd0, exp[14:11]});
        chk("R10 write-back", {14'd0, act[10:8]}, {14'd0, exp[10:8]});
        chk("R11 memory", {13'd0, act[7:4]}, {13'd0, exp[7:4]});
        chk("R12 pc write", {13'd0, act[3:0]}, {13'd0, exp[3:0]});
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      opcode = opList[lfsr[2:0]];
      if (cyc < 3) rst = 1'b1;
      else if (!midDone && cyc >= 200 && mState == 1) begin
        rst = 1'b1; midDone = 1; opcode = 6'b000000;             // R14 collision
      end else rst = 1'b0;
      @(posedge clk);
      if (rst) begin
        tag = (cyc >= 3) ? "R14 reset over dispatch" : "R1 reset";
        mState = 0;
      end else begin
        case (mState)
          0: begin mState = 1; tag = "R6 seq"; end
          1: begin
            mState = disp1(opcode);
            tag = (mState == 0) ? "R4 unlisted" : "R3 dispatch1";
          end
          2: begin mState = disp2(opcode); tag = "R5 dispatch2"; end
          3, 6, 10: begin mState = mState + 1; tag = "R13 opcode ignored"; end
          default: begin mState = 0; tag = "R7 return"; end
        endcase
      end
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R6 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule